// File: doc/BRIEF.md
# Flash Bank Erase/Program Sequencer

This block drives a byte-wide flash part that takes commands through writes and reports progress through a status byte. A request names an operation (erase a whole bank, or program every byte of a bank) and a bank index. The sequencer issues the command pairs on a simple flash bus, polls the status byte until the part reports completion, and then returns the part to array-read mode. A read-back pass follows: after an erase each byte must be blank, and after a program each byte must equal the source data.

Program data comes from a fetch port. The sequencer presents a byte offset on `src_addr` and takes `src_data` in the same cycle. A bank spans `2**OFS_W` bytes, so the bank base address is the bank index shifted left by `OFS_W`. With the default `OFS_W` of 13 this gives a base of index times 0x2000. The wait between a program setup write and its data write is set as a count of clock cycles.

Three flags report errors. `err_status` records fault bits seen in a completed status byte, `err_timeout` records polling that gave up, and `err_verify` records a read-back mismatch. All three hold until the next accepted request.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held (synchronous, active low) and after it is released with no request, `busy`, `done`, `fl_we`, `fl_re`, `err_status`, `err_timeout` and `err_verify` are all 0. `fl_we` and `fl_re` are never high in the same cycle.
- R2: An erase writes 0x20 and then 0xD0, both to the bank base address `{bank, OFS_W zeros}`, and then starts status polling. Bytes of other banks are left untouched.
- R3: Each poll attempt writes 0x70 to the base address and then reads the base address once. Bit 7 of the byte read means complete. When the part answers not-ready N times, exactly N+1 status reads occur.
- R4: A program visits offsets 0 to `2**OFS_W-1` in increasing order. For each offset it writes 0x40 to `{bank, offset}`, then writes `src_data` (fetched with `src_addr` = offset) to that same address, then polls. The data write comes exactly `GAP_CYCLES+1` cycles after the setup write, so `GAP_CYCLES` cycles without a write lie between them.
- R5: After the operation, whether it completed or timed out, the sequencer writes 0x50 and then 0xFF to the base address, once each, before any read-back.
- R6: A completed status byte with any of bits 5, 4 or 3 set (mask 0x38) sets `err_status`. Other bits do not set it. The flag stays set until the next accepted request clears it.
- R7: After an erase, every byte of the bank is read back. Any byte other than 0xFF sets `err_verify`.
- R8: After a program, every byte of the bank is read back and compared with `src_data` at the same offset. Any difference sets `err_verify`.
- R9: If `POLL_LIMIT` status reads in a row all show not-ready, `err_timeout` is set. During a program this also stops the byte loop, so no further bytes are written. The end commands (R5) and the full read-back still run.
- R10: A request is taken only when the block is idle. `req_valid` raised while `busy` is high has no effect.
- R11: `busy` rises in the cycle after an accepted request. `done` is high for exactly one cycle at the end, and `busy` is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_prog | input | 1 | 1 = program bank, 0 = erase bank |
| req_bank | input | BANK_W | Bank index |
| src_addr | output | OFS_W | Offset of the source byte wanted |
| src_data | input | 8 | Source byte for `src_addr`, same cycle |
| fl_addr | output | BANK_W+OFS_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data or command |
| fl_rdata | input | 8 | Flash read data, sampled at the edge ending an `fl_re` cycle |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| err_status | output | 1 | Fault bits seen in a completed status byte |
| err_timeout | output | 1 | Polling gave up |
| err_verify | output | 1 | Read-back mismatch |

## Verification
A wrong sequencer state shows up on the flash bus within one or two cycles. It appears as a command byte out of order, a write to a non-base address, a setup-to-data spacing off by a cycle, or an extra or missing status read. The bench's flash model counts each of these per operation. A miscounting byte index or poll counter appears later, when the operation ends. It leaves bank bytes that differ from the arithmetic image, or data writes that continue after a timeout, or status reads that are not exactly one more than the programmed latency. Sweeps over latency up to and past `POLL_LIMIT`, over every single status bit, and over every bank expose both kinds of fault.

// File: rtl/flash_seq_pkg.sv
// Shared command bytes, status decoding and sequencer state type.
package flash_seq_pkg;

    localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
    localparam logic [7:0] CMD_PROG_ARM   = 8'h40;
    localparam logic [7:0] CMD_STAT_QUERY = 8'h70;
    localparam logic [7:0] CMD_STAT_CLEAR = 8'h50;
    localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;

    localparam int         STAT_READY_BIT = 7;
    localparam logic [7:0] STAT_FAULT_MASK = 8'h38;
    localparam logic [7:0] BLANK_BYTE      = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ERA_ARM,
        S_ERA_GO,
        S_PRG_ARM,
        S_PRG_GAP,
        S_PRG_DATA,
        S_POLL_CMD,
        S_POLL_RD,
        S_CLEAR,
        S_ARRAY,
        S_VERIFY,
        S_DONE
    } seq_state_e;

    typedef enum logic {
        OP_ERASE   = 1'b0,
        OP_PROGRAM = 1'b1
    } seq_op_e;

endpackage

// File: rtl/seq_gap_timer.sv
// Setup-to-data spacing timer.
// Loading it starts a window of GAP_CYCLES cycles. `expired` is high in the
// last cycle of the window and stays high while idle.
// Assumes GAP_CYCLES >= 1.
module seq_gap_timer #(
    parameter int GAP_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count down from GAP_CYCLES-1 to zero after each load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(GAP_CYCLES - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: once running, the window shrinks by exactly one per cycle.
    a_r4_gap_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/seq_poll_counter.sv
// Status-poll attempt counter.
// `last_try` is high while the read in progress is attempt number
// POLL_LIMIT. The owner bumps the count only on a not-ready read that is
// not the last try, so the count stays below POLL_LIMIT.
module seq_poll_counter #(
    parameter int POLL_LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last_try
);
    localparam int CNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    logic [CNT_W-1:0] tries;

    // Track failed status reads since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tries <= '0;
        else if (clear)
            tries <= '0;
        else if (bump)
            tries <= tries + 1'b1;
    end

    assign last_try = (tries == CNT_W'(POLL_LIMIT - 1));

    // R9: the attempt count never passes the limit.
    a_r9_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tries) < POLL_LIMIT));

    // R9: no bump is requested on the final attempt.
    a_r9_no_bump_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !(bump && last_try));

endmodule

// File: rtl/seq_byte_index.sv
// Byte offset within a bank, used by the program loop and the read-back.
// `at_end` marks the last offset of the bank.
module seq_byte_index #(
    parameter int OFS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [OFS_W-1:0] idx,
    output logic             at_end
);
    // Walk offsets upward from zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clear)
            idx <= '0;
        else if (step)
            idx <= idx + 1'b1;
    end

    assign at_end = &idx;

    // R4: each step moves to the next offset and never skips one.
    a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (idx == OFS_W'($past(idx) + 1'b1)));

endmodule

// File: rtl/flash_cmd_seq.sv
// Bank erase / program sequencer for a command-and-status flash part.
// Assumptions: fl_rdata is valid during any fl_re cycle and is sampled at
// the closing edge; src_data answers src_addr in the same cycle; each
// fl_we or fl_re cycle is one complete bus access.
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int BANK_W     = 1,
    parameter int OFS_W      = 13,
    parameter int GAP_CYCLES = 125,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_prog,
    input  logic [BANK_W-1:0]       req_bank,
    output logic [OFS_W-1:0]        src_addr,
    input  logic [7:0]              src_data,
    output logic [BANK_W+OFS_W-1:0] fl_addr,
    output logic [7:0]              fl_wdata,
    input  logic [7:0]              fl_rdata,
    output logic                    fl_we,
    output logic                    fl_re,
    output logic                    busy,
    output logic                    done,
    output logic                    err_status,
    output logic                    err_timeout,
    output logic                    err_verify
);
    localparam int FA_W = BANK_W + OFS_W;

    seq_state_e        state, state_nx;
    seq_op_e           op_q;
    logic [BANK_W-1:0] bank_q;

    logic             accept;
    logic             gap_load, gap_expired;
    logic             poll_clear, poll_bump, poll_last;
    logic             idx_clear, idx_step, idx_end;
    logic [OFS_W-1:0] idx;
    logic             poll_ready, poll_fault, poll_give_up;
    logic [7:0]       vrf_expect;
    logic [FA_W-1:0]  base_addr, byte_addr;

    assign accept       = (state == S_IDLE) && req_valid;
    assign poll_ready   = fl_rdata[STAT_READY_BIT];
    assign poll_fault   = |(fl_rdata & STAT_FAULT_MASK);
    assign poll_give_up = (state == S_POLL_RD) && !poll_ready && poll_last;
    assign vrf_expect   = (op_q == OP_PROGRAM) ? src_data : BLANK_BYTE;
    assign base_addr    = {bank_q, {OFS_W{1'b0}}};
    assign byte_addr    = {bank_q, idx};

    seq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .expired (gap_expired)
    );

    seq_poll_counter #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clear),
        .bump     (poll_bump),
        .last_try (poll_last)
    );

    seq_byte_index #(.OFS_W(OFS_W)) u_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (idx_clear),
        .step   (idx_step),
        .idx    (idx),
        .at_end (idx_end)
    );

    // Helper control strobes derived from the current state.
    always_comb begin
        gap_load   = (state == S_PRG_ARM);
        poll_clear = (state == S_ERA_GO) || (state == S_PRG_DATA);
        poll_bump  = (state == S_POLL_RD) && !poll_ready && !poll_last;
        idx_clear  = accept || (state == S_ARRAY);
        idx_step   = ((state == S_POLL_RD) && poll_ready &&
                      (op_q == OP_PROGRAM) && !idx_end) ||
                     ((state == S_VERIFY) && !idx_end);
    end

    // Next-state decision for the command sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = req_prog ? S_PRG_ARM : S_ERA_ARM;
            S_ERA_ARM:  state_nx = S_ERA_GO;
            S_ERA_GO:   state_nx = S_POLL_CMD;
            S_PRG_ARM:  state_nx = S_PRG_GAP;
            S_PRG_GAP:  if (gap_expired) state_nx = S_PRG_DATA;
            S_PRG_DATA: state_nx = S_POLL_CMD;
            S_POLL_CMD: state_nx = S_POLL_RD;
            S_POLL_RD: begin
                if (poll_ready)
                    state_nx = ((op_q == OP_PROGRAM) && !idx_end) ? S_PRG_ARM : S_CLEAR;
                else if (poll_last)
                    state_nx = S_CLEAR;
                else
                    state_nx = S_POLL_CMD;
            end
            S_CLEAR:    state_nx = S_ARRAY;
            S_ARRAY:    state_nx = S_VERIFY;
            S_VERIFY:   if (idx_end) state_nx = S_DONE;
            S_DONE:     state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State, latched request and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            op_q        <= OP_ERASE;
            bank_q      <= '0;
            err_status  <= 1'b0;
            err_timeout <= 1'b0;
            err_verify  <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q        <= req_prog ? OP_PROGRAM : OP_ERASE;
                bank_q      <= req_bank;
                err_status  <= 1'b0;
                err_timeout <= 1'b0;
                err_verify  <= 1'b0;
            end else begin
                if ((state == S_POLL_RD) && poll_ready && poll_fault)
                    err_status <= 1'b1;
                if (poll_give_up)
                    err_timeout <= 1'b1;
                if ((state == S_VERIFY) && (fl_rdata != vrf_expect))
                    err_verify <= 1'b1;
            end
        end
    end

    // Flash bus drive for each state.
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = base_addr;
        fl_wdata = 8'h00;
        unique case (state)
            S_ERA_ARM:  begin fl_we = 1'b1; fl_wdata = CMD_ERASE_ARM;  end
            S_ERA_GO:   begin fl_we = 1'b1; fl_wdata = CMD_ERASE_GO;   end
            S_PRG_ARM:  begin fl_we = 1'b1; fl_wdata = CMD_PROG_ARM;   fl_addr = byte_addr; end
            S_PRG_DATA: begin fl_we = 1'b1; fl_wdata = src_data;       fl_addr = byte_addr; end
            S_POLL_CMD: begin fl_we = 1'b1; fl_wdata = CMD_STAT_QUERY; end
            S_POLL_RD:  begin fl_re = 1'b1; end
            S_CLEAR:    begin fl_we = 1'b1; fl_wdata = CMD_STAT_CLEAR; end
            S_ARRAY:    begin fl_we = 1'b1; fl_wdata = CMD_ARRAY_MODE; end
            S_VERIFY:   begin fl_re = 1'b1; fl_addr = byte_addr; end
            default:    ;
        endcase
    end

    assign src_addr = idx;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);

    // R1: the two strobes are exclusive.
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R10: the latched request does not change while an operation runs.
    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> ($stable(bank_q) && $stable(op_q)));

    // R11: done is a single-cycle pulse followed by idle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6: a fault flag survives until a new request is accepted.
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !accept) |=> err_status);

    // R9: giving up on polling moves straight to the clear command.
    a_r9_giveup_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
        poll_give_up |=> (fl_we && fl_wdata == CMD_STAT_CLEAR));

    // R5: the clear command is followed at once by the array-mode command.
    a_r5_clear_then_array: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLEAR) |=> (fl_we && fl_wdata == CMD_ARRAY_MODE && fl_addr == base_addr));

endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
// Bench: small banks, short gap and poll limit, a behavioural flash model
// that checks command order, and arithmetic expected memory images.
module tb_flash_cmd_seq;
    localparam int BANK_W = 2;
    localparam int OFS_W  = 3;
    localparam int GAP    = 3;
    localparam int LIMIT  = 6;
    localparam int NBYTE  = 1 << OFS_W;
    localparam int NMEM   = NBYTE << BANK_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_prog = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [OFS_W-1:0] src_addr;
    logic [7:0] src_data;
    logic [BANK_W+OFS_W-1:0] fl_addr;
    logic [7:0] fl_wdata;
    logic [7:0] fl_rdata;
    logic fl_we, fl_re, busy, done, err_status, err_timeout, err_verify;

    always #4 clk = ~clk;

    int seed = 0;
    function automatic logic [7:0] pat(input int s, input int a);
        return 8'((s * 29 + a * 53 + 7) ^ (a << 4));
    endfunction
    assign src_data = pat(seed, int'(src_addr));

    flash_cmd_seq #(.BANK_W(BANK_W), .OFS_W(OFS_W), .GAP_CYCLES(GAP), .POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
        .req_bank(req_bank), .src_addr(src_addr), .src_data(src_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_we(fl_we), .fl_re(fl_re), .busy(busy), .done(done),
        .err_status(err_status), .err_timeout(err_timeout), .err_verify(err_verify)
    );

    // ---------------- flash model (acts at negedge) ----------------
    logic [7:0] mem [NMEM];
    logic [7:0] exp_mem [NMEM];
    logic [7:0] rdata_q = 8'h00;
    assign fl_rdata = rdata_q;

    int lat = 0;
    bit stuck = 0;
    logic [7:0] inj = 8'h00;
    bit mode_stat = 0, erase_armed = 0, prog_armed = 0, after_clear = 0;
    int busy_left = 0, cyc = 0, arm_cyc = 0, prog_idx = 0;
    int arm_addr = 0;
    int n_polls, n_data, n_erase, n_clear, n_array, proto_err, gap_min, gap_max, n_done;

    always @(negedge clk) begin
        cyc++;
        if (done) n_done++;
        if (rst_n && fl_we) begin
            automatic int a   = int'(fl_addr);
            automatic int off = a % NBYTE;
            automatic int bk  = a / NBYTE;
            if (prog_armed) begin
                automatic int g = cyc - arm_cyc;
                prog_armed = 0;
                if (a != arm_addr || off != prog_idx) proto_err++;
                if (g < gap_min) gap_min = g;
                if (g > gap_max) gap_max = g;
                prog_idx++;
                n_data++;
                if (!stuck) mem[a] = mem[a] & fl_wdata;
                busy_left = lat;
                mode_stat = 1;
            end else if (erase_armed) begin
                erase_armed = 0;
                if (fl_wdata != 8'hD0 || off != 0) proto_err++;
                else begin
                    n_erase++;
                    if (!stuck) for (int i = 0; i < NBYTE; i++) mem[bk * NBYTE + i] = 8'hFF;
                    busy_left = lat;
                    mode_stat = 1;
                end
            end else if (after_clear) begin
                after_clear = 0;
                if (fl_wdata != 8'hFF || off != 0) proto_err++;
                else begin n_array++; mode_stat = 0; end
            end else begin
                case (fl_wdata)
                    8'h20: begin erase_armed = 1; if (off != 0) proto_err++; end
                    8'h40: begin prog_armed = 1; arm_addr = a; arm_cyc = cyc; end
                    8'h70: begin mode_stat = 1; if (off != 0) proto_err++; end
                    8'h50: begin after_clear = 1; n_clear++; if (off != 0) proto_err++; end
                    default: proto_err++;
                endcase
            end
        end
        if (rst_n && fl_re) begin
            if (mode_stat) begin
                rdata_q = (!stuck && busy_left == 0) ? (8'h80 | inj) : 8'h00;
                if (busy_left > 0) busy_left--;
                n_polls++;
                if (int'(fl_addr) % NBYTE != 0) proto_err++;
            end else begin
                rdata_q = mem[int'(fl_addr)];
            end
        end
    end

    // ---------------- checking helpers ----------------
    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < NMEM; i++) if (mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    task automatic set_bank(input int bk, input int s, input bit blank, input bit zero);
        for (int i = 0; i < NBYTE; i++) begin
            mem[bk * NBYTE + i] = blank ? 8'hFF : (zero ? 8'h00 : pat(s, i));
            exp_mem[bk * NBYTE + i] = mem[bk * NBYTE + i];
        end
    endtask

    task automatic clear_stats();
        n_polls = 0; n_data = 0; n_erase = 0; n_clear = 0; n_array = 0;
        proto_err = 0; gap_min = 1 << 30; gap_max = 0; prog_idx = 0;
        erase_armed = 0; prog_armed = 0; after_clear = 0;
    endtask

    // Issue a request and wait for done; checks the R11 handshake.
    task automatic run_op(input bit prog, input int bk);
        int w = 0;
        clear_stats();
        @(negedge clk);
        req_prog = prog; req_bank = BANK_W'(bk); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R11 busy after accept", int'(busy), 1);
        while (!done && w < 3000) begin @(negedge clk); w++; end
        check(done == 1'b1, "R11 done reached", int'(done), 1);
        @(negedge clk);
        check(!done && !busy, "R11 done single cycle then idle", int'({done, busy}), 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < NMEM; i++) begin mem[i] = 8'h5A; exp_mem[i] = 8'h5A; end
        clear_stats();
        n_done = 0;
        repeat (4) @(negedge clk);
        check(!busy && !done && !fl_we && !fl_re, "R1 outputs in reset",
              int'({busy, done, fl_we, fl_re}), 0);
        check(!err_status && !err_timeout && !err_verify, "R1 flags in reset",
              int'({err_status, err_timeout, err_verify}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done && !fl_we && !fl_re, "R1 idle after reset",
              int'({busy, done, fl_we, fl_re}), 0);

        // Erase sweep over not-ready latency, every bank (R2, R3, R5, R7).
        for (int l = 0; l < LIMIT; l++) begin
            automatic int bk = l % (1 << BANK_W);
            set_bank(bk, 0, 0, 1);
            lat = l;
            run_op(0, bk);
            for (int i = 0; i < NBYTE; i++) exp_mem[bk * NBYTE + i] = 8'hFF;
            check(mem_mismatch() == 0, "R2 erased bank only", mem_mismatch(), 0);
            check(n_erase == 1 && proto_err == 0, "R2 erase command pair", proto_err, 0);
            check(n_polls == l + 1, "R3 status reads", n_polls, l + 1);
            check(n_clear == 1 && n_array == 1, "R5 clear then array", n_clear + n_array, 2);
            check(!err_verify && !err_timeout && !err_status, "R7 clean erase",
                  int'({err_verify, err_timeout, err_status}), 0);
        end

        // Program every bank with its own data (R3, R4, R8).
        for (int bk = 0; bk < (1 << BANK_W); bk++) begin
            set_bank(bk, 0, 1, 0);
            seed = 11 + bk * 7;
            lat = bk;
            run_op(1, bk);
            for (int i = 0; i < NBYTE; i++) exp_mem[bk * NBYTE + i] = pat(seed, i);
            check(mem_mismatch() == 0, "R4 programmed image", mem_mismatch(), 0);
            check(n_data == NBYTE && proto_err == 0, "R4 byte order and address", n_data, NBYTE);
            check(gap_min == GAP + 1 && gap_max == GAP + 1, "R4 setup-to-data spacing",
                  gap_max, GAP + 1);
            check(n_polls == NBYTE * (bk + 1), "R3 polls per byte", n_polls, NBYTE * (bk + 1));
            check(!err_verify, "R8 clean program", int'(err_verify), 0);
        end

        // Program over non-blank contents: AND image, verify flag (R8).
        begin
            automatic int bad = 0;
            set_bank(1, 3, 0, 0);
            seed = 40;
            lat = 0;
            run_op(1, 1);
            for (int i = 0; i < NBYTE; i++) begin
                exp_mem[NBYTE + i] = pat(3, i) & pat(40, i);
                if (exp_mem[NBYTE + i] != pat(40, i)) bad = 1;
            end
            check(mem_mismatch() == 0, "R8 overwrite image", mem_mismatch(), 0);
            check(err_verify == bad, "R8 mismatch flag", int'(err_verify), bad);
        end

        // Every single status bit injected on an erase (R6).
        for (int k = 0; k < 7; k++) begin
            automatic int want = ((8'(1 << k) & 8'h38) != 0) ? 1 : 0;
            inj = 8'(1 << k);
            lat = 1;
            set_bank(0, 0, 0, 1);
            run_op(0, 0);
            for (int i = 0; i < NBYTE; i++) exp_mem[i] = 8'hFF;
            check(err_status == want, "R6 fault bit decode", int'(err_status), want);
            check(!err_verify, "R7 erase despite fault", int'(err_verify), 0);
        end
        // Fault during a program stays set to the end; next request clears it (R6).
        inj = 8'h10;
        seed = 5;
        set_bank(2, 0, 1, 0);
        run_op(1, 2);
        for (int i = 0; i < NBYTE; i++) exp_mem[2 * NBYTE + i] = pat(5, i);
        check(err_status == 1'b1, "R6 sticky over program", int'(err_status), 1);
        inj = 8'h00;
        run_op(0, 2);
        for (int i = 0; i < NBYTE; i++) exp_mem[2 * NBYTE + i] = 8'hFF;
        check(err_status == 1'b0, "R6 cleared by next request", int'(err_status), 0);

        // Latency at limit boundary (R9): LIMIT-1 not-ready is fine, LIMIT times out.
        lat = LIMIT - 1;
        run_op(0, 3);
        for (int i = 0; i < NBYTE; i++) exp_mem[3 * NBYTE + i] = 8'hFF;
        check(!err_timeout && n_polls == LIMIT, "R9 last try succeeds", n_polls, LIMIT);
        lat = LIMIT;
        run_op(0, 3);
        check(err_timeout && n_polls == LIMIT, "R9 timeout after limit", n_polls, LIMIT);
        check(n_clear == 1 && n_array == 1 && !err_verify, "R5 end commands after timeout",
              n_clear + n_array, 2);

        // Stuck erase: timeout and failed blank check (R9, R7).
        stuck = 1;
        set_bank(0, 0, 0, 1);
        run_op(0, 0);
        check(err_timeout && err_verify, "R9 R7 stuck erase flags",
              int'({err_timeout, err_verify}), 3);
        check(mem_mismatch() == 0, "R9 stuck erase leaves data", mem_mismatch(), 0);

        // Stuck program: loop stops after first byte (R9).
        set_bank(2, 0, 1, 0);
        seed = 9;
        run_op(1, 2);
        check(n_data == 1, "R9 program loop stops", n_data, 1);
        check(err_timeout && err_verify && n_clear == 1, "R9 flags after program timeout",
              int'({err_timeout, err_verify}), 3);
        stuck = 0;
        lat = 0;

        // Request while busy is ignored (R10).
        begin
            automatic int d0;
            set_bank(3, 0, 0, 1);
            set_bank(0, 0, 1, 0);
            lat = 3;
            clear_stats();
            d0 = n_done;
            @(negedge clk);
            req_prog = 1'b0; req_bank = 2'd3; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            @(negedge clk);
            req_prog = 1'b1; req_bank = 2'd0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            repeat (120) @(negedge clk);
            for (int i = 0; i < NBYTE; i++) exp_mem[3 * NBYTE + i] = 8'hFF;
            check(n_done - d0 == 1 && !busy, "R10 single operation", n_done - d0, 1);
            check(n_data == 0 && mem_mismatch() == 0, "R10 busy request ignored", n_data, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule